// File: doc/BRIEF.md
# Bidirectional Two-Digit Seconds Timer

This block measures up to thirty seconds in either direction. It stores the elapsed or remaining time as two binary-coded decimal digits: a units digit and a tens digit. An internal divider turns the fast system clock into a one-cycle enable once per second. That enable steps the units digit, and the units digit's wrap steps the tens digit within the same clock cycle. Selecting up mode preloads 00 and counting stops at 30. Selecting down mode preloads 30 and counting stops at 00. An active-low alarm marks the end value and freezes the count until the count is reloaded.

A small two-state machine, with states HALT and GO, records whether timing is running. In HALT the digits hold. In GO the digits advance on every tick unless the alarm is active. There is one transition in each direction, HALT to GO and GO to HALT. Both are taken on a one-cycle start pulse, but only while the alarm is inactive. A start pulse that arrives during the alarm leaves the state unchanged.

A clear input (active high) and a load input (active low) act at the next clock edge, with no wait for a tick. Changing the direction input also triggers a load. All logic runs on one clock with a synchronous reset.

Top module: `updown_sec_timer`

## Requirements
- R1: A synchronous active-high reset sets both digits to 0, selects up mode, places the run state machine in HALT and drives the alarm high (inactive). After reset the digits stay at 00 until a start pulse arrives.
- R2: Each digit always holds a value from 0 to 9. While in GO with the alarm inactive, the count (tens×10 + units) changes by exactly one once every TICK_DIV clock cycles.
- R3: In up mode, the units digit wraps from 9 to 0 and increments the tens digit on the same clock edge (09 becomes 10, 19 becomes 20).
- R4: In down mode, the units digit wraps from 0 to 9 and decrements the tens digit on the same clock edge (30 becomes 29, 10 becomes 09).
- R5: In up mode, the alarm output is 0 exactly while the count is 30. The count then holds.
- R6: In down mode, the alarm output is 0 exactly while the count is 00. The count then holds.
- R7: Direction input 1 selects down mode and 0 selects up mode. A change of the direction input loads the new mode's start value at the next clock edge, whatever the tick phase: 30 for down mode, 00 for up mode. A count of 00 in up mode does not raise the alarm.
- R8: A one-cycle start pulse with the alarm inactive toggles between HALT and GO. In HALT the count holds.
- R9: A start pulse received while the alarm is active has no effect on the run state. After a reload, counting resumes exactly as it was before the alarm.
- R10: A clear input at 1 sets both digits to 0 at the next clock edge. It takes priority over load, over a direction change and over counting.
- R11: A load input at 0 sets the digits to the current mode's start value at the next clock edge, whatever the tick phase. It takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_down_i | input | 1 | Mode select: 1 for down, 0 for up |
| start_i | input | 1 | One-cycle pulse that toggles between run and pause |
| clr_i | input | 1 | Clears the digits to 00, active high |
| load_n_i | input | 1 | Loads the mode's start value, active low |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |
| alarm_n_o | output | 1 | End-of-count alarm, active low |

## Verification
A units digit with a wrong value or a lost carry shows up at the ports on the very next tick. It appears as a count that skips, repeats or leaves BCD range, and the bench detects it by comparing every cycle against an integer model of elapsed seconds. A wrong run state shows up one tick later, as digits that move while paused or stay still while running. A wrong alarm decode appears in the same cycle the limit is reached, or when 00 is loaded in up mode. It then persists, because the count either overshoots or freezes. The tests drive full up and down sweeps through every carry and borrow, apply reloads at arbitrary tick phases and pulse start during the alarm.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int          BCD_W      = 4;
    localparam int          NUM_DIGITS = 2;
    localparam logic [3:0]  DIGIT_MAX  = 4'd9;
    localparam logic [3:0]  TOP_TENS   = 4'd3;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic {
        RUN_HALT = 1'b0,
        RUN_GO   = 1'b1
    } run_state_t;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    always_comb tick_o = (cnt_q == LAST);

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R2: ticks are single-cycle pulses
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic load_i,
    input  bcd_t load_val_i,
    input  logic en_i,
    input  logic down_i,
    output bcd_t value_o,
    output logic wrap_o
);
    bcd_t value_q;

    always_ff @(posedge clk) begin
        if (rst)         value_q <= '0;
        else if (clr_i)  value_q <= '0;
        else if (load_i) value_q <= load_val_i;
        else if (en_i) begin
            if (down_i) value_q <= (value_q == '0)       ? DIGIT_MAX : value_q - 1'b1;
            else        value_q <= (value_q == DIGIT_MAX) ? '0        : value_q + 1'b1;
        end
    end

    always_comb begin
        value_o = value_q;
        wrap_o  = en_i && (down_i ? (value_q == '0) : (value_q == DIGIT_MAX));
    end

    // R2: digit stays in decimal range
    assert_digit_bcd_R2: assert property (@(posedge clk) disable iff (rst)
        value_q <= DIGIT_MAX);
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic alarm_i,
    output logic run_o
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RUN_HALT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALT: if (start_i && !alarm_i) state_d = RUN_GO;
            RUN_GO:   if (start_i && !alarm_i) state_d = RUN_HALT;
        endcase
    end

    always_comb run_o = (state_q == RUN_GO);

    // R8: start pulse toggles
    assert_halt_to_go_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !alarm_i && state_q == RUN_HALT) |=> state_q == RUN_GO);
    assert_go_to_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !alarm_i && state_q == RUN_GO) |=> state_q == RUN_HALT);
    // R9: start ignored during alarm
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && alarm_i) |=> $stable(state_q));
endmodule

// File: rtl/updown_sec_timer.sv
module updown_sec_timer
    import timer_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_down_i,
    input  logic       start_i,
    input  logic       clr_i,
    input  logic       load_n_i,
    output logic [3:0] units_o,
    output logic [3:0] tens_o,
    output logic       alarm_n_o
);
    logic tick, run, alarm, count_en, load_req, dir_q;
    bcd_t digit [NUM_DIGITS];
    logic step  [NUM_DIGITS+1];
    logic wrap  [NUM_DIGITS];

    tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    run_ctrl u_run (
        .clk(clk), .rst(rst), .start_i(start_i), .alarm_i(alarm), .run_o(run)
    );

    always_ff @(posedge clk) begin
        if (rst) dir_q <= 1'b0;
        else     dir_q <= dir_down_i;
    end

    always_comb begin
        load_req = (dir_down_i != dir_q) || !load_n_i;
        alarm    = (digit[0] == '0) &&
                   (digit[NUM_DIGITS-1] == (dir_q ? bcd_t'(0) : TOP_TENS));
        count_en = run && !alarm && tick;
        step[0]  = count_en;
    end

    generate
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
            localparam bit IS_TOP = (i == NUM_DIGITS - 1);
            bcd_t preset;
            always_comb preset = (IS_TOP && dir_down_i) ? TOP_TENS : bcd_t'(0);

            bcd_digit u_dig (
                .clk(clk), .rst(rst), .clr_i(clr_i), .load_i(load_req),
                .load_val_i(preset), .en_i(step[i]), .down_i(dir_q),
                .value_o(digit[i]), .wrap_o(wrap[i])
            );
            always_comb step[i+1] = wrap[i];
        end
    endgenerate

    always_comb begin
        units_o   = digit[0];
        tens_o    = digit[NUM_DIGITS-1];
        alarm_n_o = !alarm;
    end

    // R5/R6: count frozen while alarm
    assert_hold_at_alarm_R5: assert property (@(posedge clk) disable iff (rst)
        (!alarm_n_o && !clr_i && !load_req) |=> ($stable(units_o) && $stable(tens_o)));
    // R7: direction change preloads
    assert_dir_load_R7: assert property (@(posedge clk) disable iff (rst)
        ((dir_down_i != dir_q) && !clr_i) |=>
            (units_o == 4'd0 && tens_o == (dir_q ? TOP_TENS : 4'd0)));
    // R10: clear wins
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (units_o == 4'd0 && tens_o == 4'd0));
    // R2: no movement without tick or reload
    assert_no_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr_i && !load_req) |=> ($stable(units_o) && $stable(tens_o)));
endmodule

// File: tb/updown_sec_timer_tb.sv
module updown_sec_timer_tb;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst = 1'b1, dir_down = 1'b0, start = 1'b0, clr = 1'b0, load_n = 1'b1;
    logic [3:0] units, tens;
    logic alarm_n;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit mon_en = 0, done = 0;

    // reference model state
    int m_div = 0, m_val = 0;
    bit m_down = 0, m_run = 0;

    always #10 clk = ~clk;

    updown_sec_timer #(.TICK_DIV(D)) u_dut (
        .clk(clk), .rst(rst), .dir_down_i(dir_down), .start_i(start),
        .clr_i(clr), .load_n_i(load_n), .units_o(units), .tens_o(tens),
        .alarm_n_o(alarm_n)
    );

    function automatic int dut_val();
        return int'(tens) * 10 + int'(units);
    endfunction

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_state(string req, int exp_val, bit exp_an);
        chk(req, units <= 9 && tens <= 9 && dut_val() == exp_val, dut_val(), exp_val);
        chk(req, alarm_n == exp_an, alarm_n, exp_an);
    endtask

    // model of elapsed seconds, driven by the requirements
    always @(posedge clk) begin
        bit tk, al, old_run;
        if (rst) begin
            m_div = 0; m_val = 0; m_down = 0; m_run = 0;
        end else begin
            tk = (m_div == D - 1);
            m_div = tk ? 0 : m_div + 1;
            al = m_down ? (m_val == 0) : (m_val == 30);
            old_run = m_run;
            if (start && !al) m_run = !m_run;
            if (clr) m_val = 0;
            else if ((dir_down != m_down) || !load_n) m_val = dir_down ? 30 : 0;
            else if (old_run && !al && tk) m_val = m_down ? m_val - 1 : m_val + 1;
            m_down = dir_down;
        end
    end

    always @(negedge clk) begin
        if (mon_en) chk_state(cur_req, m_val,
                              !(m_down ? (m_val == 0) : (m_val == 30)));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_alarm();
        for (int i = 0; i < 400 && alarm_n; i++) @(negedge clk);
    endtask

    initial begin
        int v, gap;
        cyc(3);
        rst = 1'b0;
        mon_en = 1;
        @(negedge clk);
        chk_state("R1", 0, 1'b1);
        cyc(12);
        chk_state("R1", 0, 1'b1);          // halted after reset

        cur_req = "R3";
        pulse_start();                      // R8 HALT->GO
        wait_alarm();
        cur_req = "R5";
        chk_state("R5", 30, 1'b0);
        cyc(10);
        chk_state("R5", 30, 1'b0);

        cur_req = "R9";
        pulse_start();                      // ignored during alarm
        cyc(4);
        chk_state("R9", 30, 1'b0);
        @(negedge clk) dir_down = 1'b1;     // R7 load 30
        @(negedge clk);
        chk_state("R7", 30, 1'b1);
        cur_req = "R4";
        cyc(4 * D + 2);
        chk("R9", dut_val() < 30, dut_val(), 29);
        wait_alarm();
        cur_req = "R6";
        chk_state("R6", 0, 1'b0);
        cyc(8);
        chk_state("R6", 0, 1'b0);

        cur_req = "R7";
        @(negedge clk) dir_down = 1'b0;
        @(negedge clk);
        chk_state("R7", 0, 1'b1);           // 00 in up mode is no alarm
        cyc(5 * D);

        cur_req = "R8";
        pulse_start();                      // GO->HALT
        v = dut_val();
        cyc(5 * D);
        chk("R8", dut_val() == v, dut_val(), v);
        pulse_start();                      // HALT->GO
        cyc(3 * D);
        chk("R8", dut_val() > v, dut_val(), v + 1);

        cur_req = "R10";
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk_state("R10", 0, 1'b1);
        @(negedge clk) dir_down = 1'b1;
        cyc(2 * D + 1);
        clr = 1'b1; load_n = 1'b0;
        @(negedge clk) begin clr = 1'b0; load_n = 1'b1; end
        chk_state("R10", 0, 1'b0);          // clear beats load, 00 alarms in down mode

        cur_req = "R11";
        @(negedge clk) load_n = 1'b0;
        @(negedge clk) load_n = 1'b1;
        chk_state("R11", 30, 1'b1);
        cyc(D + 1);
        @(negedge clk) load_n = 1'b0;
        @(negedge clk) load_n = 1'b1;
        chk_state("R11", 30, 1'b1);

        cur_req = "R2";
        v = dut_val();
        for (int i = 0; i < 10 * D && dut_val() == v; i++) @(negedge clk);
        v = dut_val();
        gap = 0;
        for (int i = 0; i < 10 * D && dut_val() == v; i++) begin
            @(negedge clk);
            gap++;
        end
        chk("R2", gap == D, gap, D);
        chk("R2", dut_val() == v - 1, dut_val(), v - 1);

        cyc(40 * D);
        mon_en = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule